// File: doc/BRIEF.md
# Handshaked Real-Time Clock Register Block

This block keeps wall-clock time as a 32-bit seconds count and a sub-second fraction count. The fraction advances once per cycle in which the `tick_en` input is high. When it rolls over, the seconds count goes up by one. A seconds/fraction alarm comparator raises an alarm flag when the running time equals the programmed alarm time. A status register reports the alarm, the write handshake and a power-up "not valid" condition. An enable register picks which of these flags drive the single interrupt line.

Software reaches seven 32-bit registers through a word-addressed port. Writes do not take effect at once. Each write is parked in a single pending slot for a fixed number of clocks before it lands. Software polls the completion or error flag to learn the outcome. A write that arrives while the slot is still occupied is thrown away and flagged. The counter stays frozen until its seconds register has been written at least once. The block comes out of reset marked not valid, and it stays that way until software clears the flag.

Register offsets (word address): 0 seconds, 1 fraction, 2 alarm seconds, 3 alarm fraction, 4 control (bit 3 = run), 5 status, 6 interrupt enable. Status bits: 10 busy, 9 next, 8 complete, 7 error, 4 alarm, 1 not valid, 0 violation (always 0 here). Interrupt-enable bits: 9 next, 8 complete, 7 error, 4 alarm.

Top module: `rtc_vault`

## Requirements
- R1: After reset, status reads 0x2 (only not-valid set), seconds, fraction, control and interrupt enable read 0, alarm seconds reads 0xFFFFFFFF, and `irq` is low.
- R2: The fraction counter is FRAC_W bits wide and wraps from 2^FRAC_W-1 to 0. On that wrap the seconds count increments, and the seconds count itself wraps from 0xFFFFFFFF to 0.
- R3: A write accepted while the slot is free sets busy (bit 10) and clears next (bit 9) and complete (bit 8). Exactly LAT clocks after acceptance, the value lands in its register, busy clears, and next and complete set.
- R4: A status write acts on its landing as write-1-to-clear on bits 8, 7 and 4. Complete (bit 8) is then set again unless bit 8 was among the bits written.
- R5: A write presented while busy is set is discarded, leaving the target register unchanged, and sets error (bit 7).
- R6: The counter does not advance, even with run set and ticks present, until seconds (offset 0) has been written once after reset.
- R7: Once seconded and running, each cycle with `tick_en` high advances the time by one fraction step. Written seconds and fraction values are read back exactly.
- R8: Time advances only while control bit 3 is 1, and control reads back only bit 3.
- R9: Not-valid (bit 1) clears only through a status write with bits 1 and 0 both 1. A write with bit 1 alone leaves it set.
- R10: The alarm flag (bit 4) sets when seconds and fraction equal the alarm seconds and alarm fraction, unless alarm seconds is 0xFFFFFFFF, which disables matching.
- R11: `irq` is registered, high one clock after any of next, complete, error or alarm is set together with its enable bit (same bit positions), low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Fraction step enable |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one clock after a read strobe |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with FRAC_W = 4, so a fraction wrap and a carry into seconds happen every 16 ticks. This puts the seconds rollover from 0xFFFFFFFF to 0, alarm hits and random time spans within short tick bursts. LAT stays at its default of 4, so the busy window is wide enough to land a second write inside it and see it dropped. The same window lets the busy status be read back while the slot is still occupied.

// File: rtl/rtc_vault_pkg.sv
package rtc_vault_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] RG_SEC   = 3'd0;
  localparam logic [ADDR_W-1:0] RG_FRAC  = 3'd1;
  localparam logic [ADDR_W-1:0] RG_ASEC  = 3'd2;
  localparam logic [ADDR_W-1:0] RG_AFRAC = 3'd3;
  localparam logic [ADDR_W-1:0] RG_CTRL  = 3'd4;
  localparam logic [ADDR_W-1:0] RG_STAT  = 3'd5;
  localparam logic [ADDR_W-1:0] RG_IEN   = 3'd6;

  localparam int B_RUN  = 3;
  localparam int B_BUSY = 10;
  localparam int B_NEXT = 9;
  localparam int B_DONE = 8;
  localparam int B_ERR  = 7;
  localparam int B_ALM  = 4;
  localparam int B_NV   = 1;
  localparam int B_SV   = 0;
endpackage

// File: rtl/rtc_vault_wrq.sv
module rtc_vault_wrq #(
  parameter int LAT = 4,
  parameter int AW  = 3,
  parameter int DW  = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_data_i,
  output logic          busy_o,
  output logic          accept_o,
  output logic          commit_o,
  output logic          drop_o,
  output logic [AW-1:0] cm_addr_o,
  output logic [DW-1:0] cm_data_o
);
  localparam int CW = $clog2(LAT) + 1;

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] slot_addr_q;
  logic [DW-1:0] slot_data_q;

  assign busy_o    = busy_q;
  assign accept_o  = req_i && !busy_q;
  assign commit_o  = busy_q && (cnt_q == CW'(LAT-1));
  assign drop_o    = req_i && busy_q;
  assign cm_addr_o = slot_addr_q;
  assign cm_data_o = slot_data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q      <= 1'b0;
      cnt_q       <= '0;
      slot_addr_q <= '0;
      slot_data_q <= '0;
    end else if (busy_q) begin
      if (commit_o) busy_q <= 1'b0;
      else          cnt_q  <= cnt_q + 1'b1;
    end else if (req_i) begin
      busy_q      <= 1'b1;
      cnt_q       <= '0;
      slot_addr_q <= req_addr_i;
      slot_data_q <= req_data_i;
    end
  end

  // R3
  commit_ends_busy_chk: assert property (@(posedge clk) disable iff (rst)
    commit_o |=> !busy_o);

  // R5
  slot_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !commit_o) |=> ($stable(slot_addr_q) && $stable(slot_data_q)));

  // R3
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    accept_o |=> busy_o);
endmodule

// File: rtl/rtc_vault_timebase.sv
module rtc_vault_timebase #(
  parameter int SW = 32,
  parameter int FW = 15,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic          wr_sec_i,
  input  logic          wr_frac_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [SW-1:0] alm_sec_i,
  input  logic [FW-1:0] alm_frac_i,
  output logic [SW-1:0] sec_o,
  output logic [FW-1:0] frac_o,
  output logic          hit_o
);
  logic [SW-1:0] sec_q;
  logic [FW-1:0] frac_q;
  logic          seeded_q;
  logic          adv;

  assign adv    = run_i && tick_i && seeded_q;
  assign sec_o  = sec_q;
  assign frac_o = frac_q;
  assign hit_o  = (alm_sec_i != '1) && (sec_q == alm_sec_i) && (frac_q == alm_frac_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q    <= '0;
      frac_q   <= '0;
      seeded_q <= 1'b0;
    end else begin
      if (wr_sec_i) begin
        sec_q    <= wdata_i[SW-1:0];
        seeded_q <= 1'b1;
      end else if (adv && (frac_q == '1)) begin
        sec_q <= sec_q + 1'b1;
      end
      if (wr_frac_i)  frac_q <= wdata_i[FW-1:0];
      else if (adv)   frac_q <= frac_q + 1'b1;
    end
  end

  // R6
  frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (!seeded_q && !wr_sec_i && !wr_frac_i) |=> ($stable(frac_o) && $stable(sec_o)));

  // R2
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && (frac_q == '1) && !wr_sec_i && !wr_frac_i) |=>
      ((frac_o == '0) && (sec_o == SW'($past(sec_o) + 1'b1))));

  // R8
  halt_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !wr_sec_i && !wr_frac_i) |=> $stable(frac_o));
endmodule

// File: rtl/rtc_vault.sv
module rtc_vault
  import rtc_vault_pkg::*;
#(
  parameter int LAT    = 4,
  parameter int FRAC_W = 15
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick_en,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  localparam int SEC_W = DATA_W;

  logic              busy, accept, commit, drop;
  logic [ADDR_W-1:0] cm_addr;
  logic [DATA_W-1:0] cm_data;
  logic [SEC_W-1:0]  sec;
  logic [FRAC_W-1:0] frac;
  logic              hit;

  logic              run_q;
  logic [SEC_W-1:0]  alm_sec_q;
  logic [FRAC_W-1:0] alm_frac_q;
  logic [3:0]        ien_q;
  logic              next_q, done_q, err_q, alm_q, nv_q;
  logic [3:0]        flag_vec;
  logic              stat_wr;
  logic [DATA_W-1:0] stat_word, ien_word;
  logic [DATA_W-1:0] rdata_q;
  logic              irq_q;

  rtc_vault_wrq #(.LAT(LAT), .AW(ADDR_W), .DW(DATA_W)) wrq_i (
    .clk(clk), .rst(rst),
    .req_i(bus_sel && bus_we), .req_addr_i(bus_addr), .req_data_i(bus_wdata),
    .busy_o(busy), .accept_o(accept), .commit_o(commit), .drop_o(drop),
    .cm_addr_o(cm_addr), .cm_data_o(cm_data)
  );

  rtc_vault_timebase #(.SW(SEC_W), .FW(FRAC_W), .DW(DATA_W)) tb_i (
    .clk(clk), .rst(rst), .run_i(run_q), .tick_i(tick_en),
    .wr_sec_i(commit && (cm_addr == RG_SEC)),
    .wr_frac_i(commit && (cm_addr == RG_FRAC)),
    .wdata_i(cm_data), .alm_sec_i(alm_sec_q), .alm_frac_i(alm_frac_q),
    .sec_o(sec), .frac_o(frac), .hit_o(hit)
  );

  assign stat_wr  = commit && (cm_addr == RG_STAT);
  assign flag_vec = {next_q, done_q, err_q, alm_q};

  always_comb begin
    stat_word         = '0;
    stat_word[B_BUSY] = busy;
    stat_word[B_NEXT] = next_q;
    stat_word[B_DONE] = done_q;
    stat_word[B_ERR]  = err_q;
    stat_word[B_ALM]  = alm_q;
    stat_word[B_NV]   = nv_q;
    stat_word[B_SV]   = 1'b0;
    ien_word          = '0;
    ien_word[B_NEXT]  = ien_q[3];
    ien_word[B_DONE]  = ien_q[2];
    ien_word[B_ERR]   = ien_q[1];
    ien_word[B_ALM]   = ien_q[0];
  end

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q      <= 1'b0;
      alm_sec_q  <= '1;
      alm_frac_q <= '0;
      ien_q      <= '0;
    end else if (commit) begin
      case (cm_addr)
        RG_ASEC:  alm_sec_q  <= cm_data[SEC_W-1:0];
        RG_AFRAC: alm_frac_q <= cm_data[FRAC_W-1:0];
        RG_CTRL:  run_q      <= cm_data[B_RUN];
        RG_IEN:   ien_q      <= {cm_data[B_NEXT], cm_data[B_DONE], cm_data[B_ERR], cm_data[B_ALM]};
        default: ;
      endcase
    end
  end

  // status flags
  always_ff @(posedge clk) begin
    if (rst) begin
      next_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      alm_q  <= 1'b0;
      nv_q   <= 1'b1;
    end else begin
      if (accept) begin
        next_q <= 1'b0;
        done_q <= 1'b0;
      end else if (commit) begin
        next_q <= 1'b1;
        done_q <= !(stat_wr && cm_data[B_DONE]);
      end
      if (drop)                         err_q <= 1'b1;
      else if (stat_wr && cm_data[B_ERR]) err_q <= 1'b0;
      if (hit)                          alm_q <= 1'b1;
      else if (stat_wr && cm_data[B_ALM]) alm_q <= 1'b0;
      if (stat_wr && cm_data[B_NV] && cm_data[B_SV]) nv_q <= 1'b0;
    end
  end

  // registered read port and interrupt
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= |(flag_vec & ien_q);
      if (bus_sel && !bus_we) begin
        case (bus_addr)
          RG_SEC:   rdata_q <= sec;
          RG_FRAC:  rdata_q <= DATA_W'(frac);
          RG_ASEC:  rdata_q <= alm_sec_q;
          RG_AFRAC: rdata_q <= DATA_W'(alm_frac_q);
          RG_CTRL:  rdata_q <= DATA_W'(run_q) << B_RUN;
          RG_STAT:  rdata_q <= stat_word;
          RG_IEN:   rdata_q <= ien_word;
          default:  rdata_q <= '0;
        endcase
      end
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = irq_q;

  // R9
  nv_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(nv_q) |-> $past(commit && (cm_addr == RG_STAT) && (cm_data[1:0] == 2'b11)));

  // R5
  drop_err_chk: assert property (@(posedge clk) disable iff (rst)
    drop |=> err_q);

  // R11
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(|(flag_vec & ien_q)));

  // R10
  alarm_set_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> alm_q);
endmodule

// File: tb/rtc_vault_tb_top.sv
module rtc_vault_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LAT  = 4;
  localparam int FW   = 4;
  localparam int FMOD = 1 << FW;

  localparam logic [2:0] A_SEC = 3'd0, A_FRAC = 3'd1, A_ASEC = 3'd2, A_AFRAC = 3'd3,
                         A_CTRL = 3'd4, A_STAT = 3'd5, A_IEN = 3'd6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [31:0] m_sec;
  int unsigned m_frac;

  rtc_vault #(.LAT(LAT), .FRAC_W(FW)) dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic wr_wait(input logic [2:0] a, input logic [31:0] d);
    bus_wr(a, d);
    repeat (LAT + 1) @(negedge clk);
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  function automatic void model_adv(input int n);
    for (int i = 0; i < n; i++) begin
      m_frac++;
      if (m_frac == FMOD) begin
        m_frac = 0;
        m_sec  = m_sec + 1;
      end
    end
  endfunction

  task automatic run_ticks(input int n, input bit counts);
    if (n > 0) begin
      @(negedge clk);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
      if (counts) model_adv(n);
    end
  endtask

  task automatic chk_time(input string req);
    logic [31:0] v;
    bus_rd(A_SEC, v);  chk(req, v, m_sec);
    bus_rd(A_FRAC, v); chk(req, v, m_frac);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int unsigned seed_val;
    seed_val = $urandom(32'h5eed);
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    bus_rd(A_STAT, v); chk("R1 status", v, 32'h2);
    bus_rd(A_SEC, v);  chk("R1 sec", v, 32'h0);
    bus_rd(A_ASEC, v); chk("R1 asec", v, 32'hFFFF_FFFF);
    bus_rd(A_CTRL, v); chk("R1 ctrl", v, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R6 frozen before seconds written
    wr_wait(A_CTRL, 32'h8);
    run_ticks(20, 1'b0);
    m_sec = 0; m_frac = 0;
    chk_time("R6 frozen");

    // R3 handshake: busy during pending, next+complete after landing
    bus_wr(A_SEC, 32'd5);
    bus_rd(A_STAT, v); chk("R3 busy", v, 32'h402);
    repeat (LAT) @(negedge clk);
    bus_rd(A_STAT, v); chk("R3 landed", v, 32'h302);
    m_sec = 5;

    // R5 dropped write during busy
    bus_wr(A_AFRAC, 32'd3);
    bus_wr(A_ASEC, 32'd7);
    repeat (LAT + 1) @(negedge clk);
    bus_rd(A_ASEC, v);  chk("R5 asec untouched", v, 32'hFFFF_FFFF);
    bus_rd(A_AFRAC, v); chk("R5 first landed", v, 32'd3);
    bus_rd(A_STAT, v);  chk("R5 error flag", v, 32'h382);

    // R4 write-1-to-clear of error and complete
    wr_wait(A_STAT, 32'h180);
    bus_rd(A_STAT, v); chk("R4 w1c", v, 32'h202);

    // R9 not-valid clearing
    wr_wait(A_STAT, 32'h2);
    bus_rd(A_STAT, v); chk("R9 bit1 only", v, 32'h302);
    wr_wait(A_STAT, 32'h3);
    bus_rd(A_STAT, v); chk("R9 cleared", v, 32'h300);
    wr_wait(A_AFRAC, 32'd0);

    // R7 counting
    run_ticks(37, 1'b1);
    chk_time("R7 count");

    // R8 run bit
    wr_wait(A_CTRL, 32'h0);
    run_ticks(10, 1'b0);
    chk_time("R8 halted");
    bus_rd(A_CTRL, v); chk("R8 ctrl", v, 32'h0);
    wr_wait(A_CTRL, 32'hFFFF_FFFF);
    bus_rd(A_CTRL, v); chk("R8 ctrl bit3", v, 32'h8);

    // R2 fraction wrap carries into seconds
    wr_wait(A_FRAC, FMOD - 1);
    m_frac = FMOD - 1;
    run_ticks(1, 1'b1);
    chk_time("R2 wrap");

    // R10 alarm match
    wr_wait(A_FRAC, 32'd0);
    wr_wait(A_SEC, 32'd100);
    m_sec = 100; m_frac = 0;
    wr_wait(A_AFRAC, 32'd3);
    wr_wait(A_ASEC, 32'd102);
    run_ticks(2*FMOD + 3, 1'b1);
    @(negedge clk);
    bus_rd(A_STAT, v); chk("R10 alarm set", v & 32'h10, 32'h10);
    chk("R11 masked", {31'b0, irq}, 32'h0);
    wr_wait(A_IEN, 32'h10);
    chk("R11 alarm irq", {31'b0, irq}, 32'h1);
    bus_rd(A_IEN, v); chk("R11 ien read", v, 32'h10);
    run_ticks(1, 1'b1);
    wr_wait(A_STAT, 32'h10);
    bus_rd(A_STAT, v); chk("R10 alarm cleared", v & 32'h10, 32'h0);
    chk("R11 irq low", {31'b0, irq}, 32'h0);

    // R11 write-complete interrupt
    wr_wait(A_IEN, 32'h100);
    chk("R11 done irq", {31'b0, irq}, 32'h1);
    wr_wait(A_STAT, 32'h100);
    chk("R11 done cleared", {31'b0, irq}, 32'h0);
    wr_wait(A_IEN, 32'h0);

    // R10 unset alarm never matches; R2 seconds rollover
    wr_wait(A_ASEC, 32'hFFFF_FFFF);
    wr_wait(A_AFRAC, 32'd0);
    wr_wait(A_FRAC, 32'd0);
    wr_wait(A_SEC, 32'hFFFF_FFFE);
    m_sec = 32'hFFFF_FFFE; m_frac = 0;
    run_ticks(FMOD + 4, 1'b1);
    chk_time("R2 near top");
    bus_rd(A_STAT, v); chk("R10 unset", v & 32'h10, 32'h0);
    run_ticks(FMOD, 1'b1);
    chk_time("R2 rollover");

    // R7 random time spans
    for (int k = 0; k < 10; k++) begin
      logic [31:0] s;
      int unsigned f, n;
      s = $urandom;
      f = $urandom % FMOD;
      n = $urandom % 200;
      wr_wait(A_FRAC, f);
      wr_wait(A_SEC, s);
      m_sec = s; m_frac = f;
      run_ticks(n, 1'b1);
      chk_time("R7 random");
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule